// File: doc/BRIEF.md
# Event Timestamp Capture Unit

This block records when an external event happens. It watches one of two event inputs, a dedicated capture pin or the output of an internal comparator, and looks for one chosen edge on it. When that edge occurs, the block copies the value of a free-running 16-bit counter into a 16-bit capture register. In the same clock cycle it sets a capture flag. If interrupts are enabled, the flag drives an interrupt request. The counter, the comparator and the interrupt controller are outside the block: the block only sees the counter value and an acknowledge pulse from the interrupt controller.

Software reaches the block over an 8-bit register bus with registered read data. The capture value is read one byte at a time. Reading the low byte also copies the high byte into a holding latch, so the two bytes always belong to the same capture. An optional noise filter passes a level only after it has been stable for four consecutive samples.

The register map has four addresses:
- Address 0: low byte of the capture register.
- Address 1: the holding latch.
- Address 2: status. Bit 0 is the capture flag.
- Address 3: control. Bit 0 selects the source, bit 1 selects the edge, bit 2 enables the filter and bit 3 enables the interrupt.

Top module: `tcap_top`

## Requirements
- R1: Control bit 0 selects the event source: 0 selects `pin_evt` and 1 selects `cmp_evt`. Activity on the input that is not selected causes no capture.
- R2: Control bit 1 selects the edge: 1 means rising and 0 means falling. A transition in the opposite direction causes no capture.
- R3: With the filter off, a transition driven before clock edge c+1 captures the `cnt_val` value that is present at edge c+3. Two synchronizer stages and one edge-detect stage account for this delay.
- R4: The capture flag (status bit 0) is set on the same edge that loads the capture register. `irq` is high exactly when the flag is set and control bit 3 is 1.
- R5: A one-cycle pulse on `irq_ack` clears the capture flag.
- R6: A bus write to address 2 with data bit 0 equal to 1 clears the flag. A write to that address with bit 0 equal to 0 leaves the flag unchanged.
- R7: If a capture and a flag clear (by write or by acknowledge) happen on the same edge, the flag ends up set.
- R8: A read of address 0 returns the low byte of the capture register. On the same edge, it loads the high byte into the holding latch.
- R9: A read of address 1 returns the holding latch, not the live high byte of the capture register.
- R10: With control bit 2 set, the level seen by the edge detector changes only after four identical consecutive samples. A pulse shorter than that is ignored, and every capture is delayed by four more cycles.
- R11: A new capture overwrites the capture register, even if the previous value has not been read.
- R12: After reset, the capture register, the holding latch, the flag, the control register and `bus_rdata` are all zero, and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_val | input | 16 | Value of the free-running counter |
| pin_evt | input | 1 | Dedicated capture pin (asynchronous) |
| cmp_evt | input | 1 | Comparator output (asynchronous) |
| irq_ack | input | 1 | Interrupt acknowledge pulse |
| bus_addr | input | 2 | Register address |
| bus_rd | input | 1 | Read strobe; data appears in `bus_rdata` after the next edge |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that the read and write strobes are never high together. They also assume that `irq_ack` is a single-cycle pulse. The stimulus meets both assumptions by issuing every bus access and every acknowledge from one task at a time, each lasting exactly one cycle. The control register is reprogrammed only while both event inputs are low and the filter history has settled, so that changing the source or the filter cannot create a false edge. Each event is held for longer than the filter window, except for the deliberate short glitch.

// File: rtl/tcap_pkg.sv
package tcap_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] A_CAPL = 2'd0;
  localparam logic [ADDR_W-1:0] A_CAPH = 2'd1;
  localparam logic [ADDR_W-1:0] A_STAT = 2'd2;
  localparam logic [ADDR_W-1:0] A_CTRL = 2'd3;
  localparam int C_SRC  = 0;
  localparam int C_RISE = 1;
  localparam int C_NC   = 2;
  localparam int C_IE   = 3;
  localparam int CTRL_W = 4;
endpackage

// File: rtl/tcap_sync_filt.sv
module tcap_sync_filt #(
  parameter int SYNC_STAGES = 2,
  parameter int NC_LEN      = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  input  logic nc_en,
  output logic dout
);
  localparam int HIST_W = NC_LEN - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic [HIST_W-1:0]      hist_q;
  logic                   filt_q;
  logic                   smp;
  logic                   all_hi;
  logic                   all_lo;

  // synchronizer chain, one flop per stage
  genvar gi;
  generate
    for (gi = 0; gi < SYNC_STAGES; gi++) begin : g_sync
      always_ff @(posedge clk) begin
        if (rst) sync_q[gi] <= 1'b0;
        else if (gi == 0) sync_q[gi] <= din;
        else sync_q[gi] <= sync_q[(gi > 0) ? gi - 1 : 0];
      end
    end
  endgenerate

  assign smp    = sync_q[SYNC_STAGES-1];
  assign all_hi = smp & (&hist_q);
  assign all_lo = ~smp & ~(|hist_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      hist_q <= '0;
      filt_q <= 1'b0;
    end else begin
      hist_q <= {hist_q[HIST_W-2:0], smp};
      if (all_hi) filt_q <= 1'b1;
      else if (all_lo) filt_q <= 1'b0;
    end
  end

  assign dout = nc_en ? filt_q : smp;

  // R10: a change of the filtered level follows a run of agreeing samples
  a_r10_filter_run: assert property (@(posedge clk) disable iff (rst)
    (!$stable(filt_q) && !$past(rst)) |-> ($past(smp) == filt_q));
endmodule

// File: rtl/tcap_core.sv
module tcap_core #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sig,
  input  logic          rise,
  input  logic [CW-1:0] cnt,
  input  logic          clr,
  output logic [CW-1:0] icr,
  output logic          flag
);
  logic prev_q;
  logic hit;

  assign hit = rise ? (sig & ~prev_q) : (~sig & prev_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      icr    <= '0;
      flag   <= 1'b0;
    end else begin
      prev_q <= sig;
      if (hit) icr <= cnt;
      if (hit) flag <= 1'b1;
      else if (clr) flag <= 1'b0;
    end
  end

  // R4: flag and captured value appear on the same edge
  a_r4_flag_with_value: assert property (@(posedge clk) disable iff (rst)
    hit |=> (flag && icr == $past(cnt)));
  // R7: set has priority over a simultaneous clear
  a_r7_set_wins: assert property (@(posedge clk) disable iff (rst)
    (hit && clr) |=> flag);
  // R5: a clear without a capture leaves the flag low
  a_r5_clear_drops: assert property (@(posedge clk) disable iff (rst)
    (clr && !hit) |=> !flag);
  // R11: without a capture the register keeps its value
  a_r11_hold: assert property (@(posedge clk) disable iff (rst)
    !hit |=> $stable(icr));
endmodule

// File: rtl/tcap_busif.sv
module tcap_busif
  import tcap_pkg::*;
#(
  parameter int CW = 16,
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  input  logic [DW-1:0]     wdata,
  input  logic [CW-1:0]     icr,
  input  logic              flag,
  output logic [DW-1:0]     rdata,
  output logic [CTRL_W-1:0] ctrl,
  output logic              flag_clr
);
  localparam int HW = CW - DW;

  logic [HW-1:0] temp_q;
  logic          unused_wbits;

  assign unused_wbits = ^wdata[DW-1:CTRL_W];
  assign flag_clr = wr && (addr == A_STAT) && wdata[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      temp_q <= '0;
      ctrl   <= '0;
    end else begin
      if (wr && addr == A_CTRL) ctrl <= wdata[CTRL_W-1:0];
      if (rd) begin
        case (addr)
          A_CAPL: begin
            rdata  <= icr[DW-1:0];
            temp_q <= icr[CW-1:DW];
          end
          A_CAPH: rdata <= temp_q;
          A_STAT: rdata <= {{(DW-1){1'b0}}, flag};
          default: rdata <= {{(DW-CTRL_W){1'b0}}, ctrl};
        endcase
      end
    end
  end

  // R8: low-byte read latches the high byte
  a_r8_temp_load: assert property (@(posedge clk) disable iff (rst)
    (rd && addr == A_CAPL) |=> (temp_q == $past(icr[CW-1:DW])));
  // R9: high-byte read returns the latch
  a_r9_high_from_temp: assert property (@(posedge clk) disable iff (rst)
    (rd && addr == A_CAPH) |=> (rdata == $past(temp_q)));
endmodule

// File: rtl/tcap_top.sv
module tcap_top
  import tcap_pkg::*;
#(
  parameter int CW          = 16,
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2,
  parameter int NC_LEN      = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CW-1:0]     cnt_val,
  input  logic              pin_evt,
  input  logic              cmp_evt,
  input  logic              irq_ack,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              irq
);
  logic [CTRL_W-1:0] ctrl;
  logic [CW-1:0]     icr;
  logic              flag;
  logic              bus_clr;
  logic              src_raw;
  logic              sig;

  assign src_raw = ctrl[C_SRC] ? cmp_evt : pin_evt;

  tcap_sync_filt #(.SYNC_STAGES(SYNC_STAGES), .NC_LEN(NC_LEN)) u_filt (
    .clk(clk), .rst(rst), .din(src_raw), .nc_en(ctrl[C_NC]), .dout(sig)
  );

  tcap_core #(.CW(CW)) u_core (
    .clk(clk), .rst(rst), .sig(sig), .rise(ctrl[C_RISE]), .cnt(cnt_val),
    .clr(bus_clr | irq_ack), .icr(icr), .flag(flag)
  );

  tcap_busif #(.CW(CW), .DW(DW)) u_bus (
    .clk(clk), .rst(rst), .addr(bus_addr), .rd(bus_rd), .wr(bus_wr),
    .wdata(bus_wdata), .icr(icr), .flag(flag), .rdata(bus_rdata),
    .ctrl(ctrl), .flag_clr(bus_clr)
  );

  assign irq = flag & ctrl[C_IE];

  // R6: writing zero to the flag bit keeps a set flag
  a_r6_zero_write: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == A_STAT && !bus_wdata[0] && !irq_ack && flag) |=> flag);
endmodule

// File: tb/tcap_top_tb.sv
`timescale 1ns/1ps
module tcap_top_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cyc = '0;
  logic [15:0] cnt_val;
  logic        pin_evt = 1'b0, cmp_evt = 1'b0, irq_ack = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic        bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        irq;
  logic        rd_seen = 1'b0;
  logic        done = 1'b0;
  int          checks = 0, errors = 0;

  typedef struct {logic [7:0] val; string tag;} exp_t;
  exp_t sb_q[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 16'd1;
  assign cnt_val = cyc * 16'd5 + 16'h1234;

  tcap_top u_dut (
    .clk(clk), .rst(rst), .cnt_val(cnt_val), .pin_evt(pin_evt), .cmp_evt(cmp_evt),
    .irq_ack(irq_ack), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  function automatic logic [15:0] fcnt(logic [15:0] x);
    return x * 16'd5 + 16'h1234;
  endfunction

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: compare each completed read against the scoreboard
  always @(posedge clk) rd_seen <= bus_rd;
  always @(negedge clk) begin
    if (rd_seen) begin
      if (sb_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL scoreboard empty actual %h expected none", bus_rdata);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        chk(e.tag, {8'h00, bus_rdata}, {8'h00, e.val});
      end
    end
  end

  task automatic rd(logic [1:0] a, logic [7:0] exp, string tag);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    sb_q.push_back('{exp, tag});
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic fire(bit use_cmp, bit lvl, int lat, output logic [15:0] exp);
    @(negedge clk);
    if (use_cmp) cmp_evt = lvl; else pin_evt = lvl;
    exp = fcnt(cyc + 16'(lat));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] ea, eb, ec;
    idle(3);
    rst = 1'b0;
    idle(1);
    chk("R12 rdata", {8'h00, bus_rdata}, 16'h0000);
    chk("R12 irq", {15'd0, irq}, 16'd0);
    rd(2'd2, 8'h00, "R12 flag");
    rd(2'd3, 8'h00, "R12 ctrl");
    rd(2'd1, 8'h00, "R12 latch");

    // pin, rising, irq enabled
    wr(2'd3, 8'h0A);
    rd(2'd3, 8'h0A, "R12 ctrl readback");
    fire(0, 1, 2, ea);
    idle(2);
    chk("R4 irq before capture", {15'd0, irq}, 16'd0);
    idle(1);
    chk("R4 irq at capture", {15'd0, irq}, 16'd1);
    rd(2'd0, ea[7:0], "R3 R8 low byte");
    rd(2'd1, ea[15:8], "R3 R9 high byte");
    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
    chk("R5 irq after ack", {15'd0, irq}, 16'd0);
    rd(2'd2, 8'h00, "R5 flag after ack");
    fire(0, 0, 2, eb);
    idle(6);
    rd(2'd2, 8'h00, "R2 falling ignored in rising mode");

    fire(0, 1, 2, ea);
    idle(5);
    wr(2'd2, 8'h00);
    rd(2'd2, 8'h01, "R6 zero write keeps flag");
    wr(2'd2, 8'h01);
    rd(2'd2, 8'h00, "R6 one write clears flag");

    // temp latch vs live, then overwrite
    rd(2'd0, ea[7:0], "R8 low byte");
    fire(0, 0, 2, eb);
    idle(100);
    fire(0, 1, 2, eb);
    idle(60);
    fire(0, 0, 2, ec);
    idle(5);
    fire(0, 1, 2, ec);
    idle(6);
    rd(2'd1, ea[15:8], "R9 latch not live");
    rd(2'd0, ec[7:0], "R11 newest low");
    rd(2'd1, ec[15:8], "R11 newest high");
    fire(0, 0, 2, eb);
    idle(6);

    // falling mode
    wr(2'd3, 8'h08);
    wr(2'd2, 8'h01);
    fire(0, 1, 2, eb);
    idle(6);
    rd(2'd2, 8'h00, "R2 rising ignored in falling mode");
    fire(0, 0, 2, eb);
    idle(6);
    rd(2'd0, eb[7:0], "R2 falling low");
    rd(2'd1, eb[15:8], "R2 falling high");

    // comparator source, rising
    wr(2'd3, 8'h0B);
    wr(2'd2, 8'h01);
    fire(0, 1, 2, eb);
    idle(6);
    fire(0, 0, 2, eb);
    idle(6);
    rd(2'd2, 8'h00, "R1 pin ignored when comparator selected");
    fire(1, 1, 2, eb);
    idle(6);
    rd(2'd0, eb[7:0], "R1 comparator low");
    rd(2'd1, eb[15:8], "R1 comparator high");
    fire(1, 0, 2, ec);
    idle(6);

    // filter on, pin, rising
    wr(2'd3, 8'h0E);
    wr(2'd2, 8'h01);
    idle(6);
    fire(0, 1, 2, eb);
    idle(2);
    fire(0, 0, 2, eb);
    idle(12);
    rd(2'd2, 8'h00, "R10 short glitch ignored");
    fire(0, 1, 6, eb);
    idle(6);
    chk("R10 irq before filtered capture", {15'd0, irq}, 16'd0);
    idle(1);
    chk("R10 irq at filtered capture", {15'd0, irq}, 16'd1);
    rd(2'd0, eb[7:0], "R10 filtered low");
    rd(2'd1, eb[15:8], "R10 filtered high");
    fire(0, 0, 6, eb);
    idle(12);

    // set wins over clear
    wr(2'd3, 8'h0A);
    wr(2'd2, 8'h01);
    idle(6);
    fire(0, 1, 2, ea);
    idle(2);
    bus_addr = 2'd2; bus_wdata = 8'h01; bus_wr = 1'b1; irq_ack = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; irq_ack = 1'b0;
    chk("R7 irq after simultaneous clear", {15'd0, irq}, 16'd1);
    rd(2'd2, 8'h01, "R7 flag kept");
    rd(2'd0, ea[7:0], "R7 value low");

    idle(3);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule